// File: doc/BRIEF.md
# Segmented Streaming Scan Unit

This block computes a running combination over a stream of values that is cut into independent segments. Each input element carries a value, a head flag and an optional end marker. For every accepted element the unit returns, one cycle later, either the combination of all elements of its segment up to and including itself (inclusive mode) or of the elements before it in the same segment (exclusive mode). A head flag discards whatever has built up so far and starts again from the new element.

Alongside the prefix stream, the unit reports every finished segment's total on a second output channel. This is what a row reduction needs, for example summing the products of one sparse-matrix row. A segment is finished either by an explicit end marker on its final element or by the arrival of the next head. Each channel uses a ready/valid handshake. The combine operator is wrapping addition by default. A parameter switches it to signed maximum.

Top module: `seg_scan_unit`

## Requirements
- R1: After reset, out_valid and sum_valid are low and in_ready is high.
- R2: In inclusive mode (excl_mode = 0), a non-head element outputs the running combination of its segment including itself. Addition wraps modulo 2^W.
- R3: An element with in_head = 1 restarts the accumulation: in inclusive mode its output equals its own value and out_first is 1.
- R4: In exclusive mode (excl_mode = 1, sampled per element), an element outputs the combination of the earlier elements of its own segment. A segment's first element outputs the identity: 0 for addition, 0x8000…0 for max.
- R5: The first element after reset, and the first element after an element accepted with in_last = 1, starts a new segment even when its in_head is 0.
- R6: When a head element arrives while a segment is still open, the open segment's total, meaning its last inclusive value, is queued on the sum channel.
- R7: An element accepted with in_last = 1 queues its own inclusive value as a segment total. If the same element also closes an open segment under R6, the older total is delivered first. sum_valid is high in the cycle after such an acceptance.
- R8: An accepted element's prefix is valid in the very next cycle. While out_valid is high and out_ready is low, out_data and out_first hold and in_ready is low.
- R9: Totals are never lost or duplicated. sum_data holds while sum_ready is low. in_ready stays low while the total queue has fewer than two free entries.
- R10: With OP = OP_MAX, the combine is signed maximum with identity equal to the most negative value, and all other rules apply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| excl_mode | input | 1 | 1 selects the exclusive prefix for the element being accepted |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit can accept an element this cycle |
| in_data | input | W | Element value |
| in_head | input | 1 | Element starts a new segment |
| in_last | input | 1 | Element ends its segment |
| out_valid | output | 1 | Prefix result present |
| out_ready | input | 1 | Consumer takes the prefix result |
| out_data | output | W | Inclusive or exclusive prefix |
| out_first | output | 1 | Result belongs to a segment's first element |
| sum_valid | output | 1 | Segment total present |
| sum_ready | input | 1 | Consumer takes the segment total |
| sum_data | output | W | Total of a finished segment |

## Verification
A directed opening sends patterns that separate the ways a segment can begin and end: a first element with a clear flag, a head closing an open segment, an explicit end marker, and a head that is also an end marker, which separates the ordering of the two queued totals. Carry-out values show that the sum wraps. Negative values show that max is a signed compare. A long random run mixes sparse and dense heads and end markers, switches between exclusive and inclusive per element, and throttles both consumers, so every prefix and total is compared against a bench model. A held sum channel fills the total queue and shows that the input stalls at the right depth.

// File: rtl/seg_scan_pkg.sv
// Shared types for the segmented scan unit.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package seg_scan_pkg;

    // Combine operator selected at elaboration time
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MAX = 1'b1
    } scan_op_e;

    // How many segment totals one accepted element queues
    typedef enum logic [1:0] {
        TOT_NONE = 2'd0,
        TOT_ONE  = 2'd1,
        TOT_TWO  = 2'd2
    } tot_push_e;

endpackage

// File: rtl/seg_scan_combine.sv
// Combine operator and its identity element.
// OP_ADD: wrapping W-bit sum, identity 0.
// OP_MAX: signed maximum, identity is the most negative W-bit value.
// Assumes: purely combinational, operands are W-bit two's complement.
module seg_scan_combine
    import seg_scan_pkg::*;
#(
    parameter int       W  = 16,
    parameter scan_op_e OP = OP_ADD
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res,
    output logic [W-1:0] ident
);

    generate
        if (OP == OP_MAX) begin : g_max
            // Signed maximum of the earlier accumulator and the new value
            always_comb begin
                res   = ($signed(lhs) > $signed(rhs)) ? lhs : rhs;
                ident = {1'b1, {(W-1){1'b0}}};
            end
        end else begin : g_add
            // Wrapping sum of the earlier accumulator and the new value
            always_comb begin
                res   = lhs + rhs;
                ident = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/seg_scan_core.sv
// Segment accumulator and prefix output register.
// Keeps the inclusive value of the open segment, forms the inclusive and
// exclusive prefix of each accepted element, and reports which segment
// totals the element closes (the older one first).
// Assumes: 'take' is high only when the element is really transferred.
module seg_scan_core
    import seg_scan_pkg::*;
#(
    parameter int       W  = 16,
    parameter scan_op_e OP = OP_ADD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [W-1:0]  in_data,
    input  logic          in_head,
    input  logic          in_last,
    input  logic          excl_mode,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic          out_first,
    output tot_push_e     tot_push,
    output logic [W-1:0]  tot_d0,
    output logic [W-1:0]  tot_d1
);

    logic [W-1:0] acc_q;
    logic         open_q;
    logic [W-1:0] comb_val;
    logic [W-1:0] ident_val;
    logic         eff_head;
    logic         close_prev;
    logic [W-1:0] incl_val;
    logic [W-1:0] excl_val;

    seg_scan_combine #(.W(W), .OP(OP)) u_op (
        .lhs   (acc_q),
        .rhs   (in_data),
        .res   (comb_val),
        .ident (ident_val)
    );

    // Flag-guarded combine: a head (real or implied) drops the accumulator
    always_comb begin
        eff_head   = in_head || !open_q;
        close_prev = in_head && open_q;
        incl_val   = eff_head ? in_data   : comb_val;
        excl_val   = eff_head ? ident_val : acc_q;
    end

    // Choose which totals this element closes and their order
    always_comb begin
        tot_push = TOT_NONE;
        tot_d0   = incl_val;
        tot_d1   = incl_val;
        if (take) begin
            if (close_prev && in_last) begin
                tot_push = TOT_TWO;
                tot_d0   = acc_q;
            end else if (close_prev) begin
                tot_push = TOT_ONE;
                tot_d0   = acc_q;
            end else if (in_last) begin
                tot_push = TOT_ONE;
            end
        end
    end

    // Running accumulator and open-segment flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            open_q <= 1'b0;
        end else if (take) begin
            acc_q  <= incl_val;
            open_q <= !in_last;
        end
    end

    // Prefix output register, held until the consumer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= excl_mode ? excl_val : incl_val;
            out_first <= eff_head;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/seg_scan_tot_fifo.sv
// Segment total queue: accepts up to two writes per cycle, one read.
// Assumes: DEPTH is a power of two and at least 2; the writer pushes only
// when has_room was high (at least two free entries).
module seg_scan_tot_fifo
    import seg_scan_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tot_push_e     push,
    input  logic [W-1:0]  d0,
    input  logic [W-1:0]  d1,
    output logic          has_room,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    input  logic          out_ready
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q;
    logic [AW-1:0] rd_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wr_nx1;
    logic          pop;

    // Derived pointers and handshake terms
    always_comb begin
        wr_nx1    = wr_q + 1'b1;
        out_valid = (cnt_q != '0);
        pop       = out_valid && out_ready;
        has_room  = (cnt_q <= CW'(DEPTH - 2));
        out_data  = mem[rd_q];
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            // Storage entry g: first or second write of the cycle
            always_ff @(posedge clk) begin
                if (push == TOT_TWO && AW'(g) == wr_nx1) begin
                    mem[g] <= d1;
                end else if (push != TOT_NONE && AW'(g) == wr_q) begin
                    mem[g] <= d0;
                end
            end
        end
    endgenerate

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_q + AW'(push);
            rd_q  <= rd_q + AW'(pop);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/seg_scan_unit.sv
// Segmented streaming scan unit (top).
// One element per cycle in; one prefix per element out a cycle later;
// finished segment totals out through a small queue.
// Assumes: excl_mode may change per element; in_data is two's complement
// when OP_MAX is selected.
module seg_scan_unit
    import seg_scan_pkg::*;
#(
    parameter int       W         = 16,
    parameter scan_op_e OP        = OP_ADD,
    parameter int       TOT_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          excl_mode,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic          in_head,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_data,
    output logic          out_first,
    output logic          sum_valid,
    input  logic          sum_ready,
    output logic [W-1:0]  sum_data
);

    logic         take;
    logic         room;
    tot_push_e    tot_push;
    logic [W-1:0] tot_d0;
    logic [W-1:0] tot_d1;

    // Accept only when the prefix slot frees and two totals can be queued
    always_comb begin
        in_ready = (!out_valid || out_ready) && room;
        take     = in_valid && in_ready;
    end

    seg_scan_core #(.W(W), .OP(OP)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .in_data   (in_data),
        .in_head   (in_head),
        .in_last   (in_last),
        .excl_mode (excl_mode),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_first (out_first),
        .tot_push  (tot_push),
        .tot_d0    (tot_d0),
        .tot_d1    (tot_d1)
    );

    seg_scan_tot_fifo #(.W(W), .DEPTH(TOT_DEPTH)) u_tot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tot_push),
        .d0        (tot_d0),
        .d1        (tot_d1),
        .has_room  (room),
        .out_valid (sum_valid),
        .out_data  (sum_data),
        .out_ready (sum_ready)
    );

endmodule

// File: rtl/seg_scan_unit_chk.sv
// Port-level properties of seg_scan_unit, bound to every instance.
module seg_scan_unit_chk
    import seg_scan_pkg::*;
#(
    parameter int       W  = 16,
    parameter scan_op_e OP = OP_ADD
) (
    input logic          clk,
    input logic          rst_n,
    input logic          excl_mode,
    input logic          in_valid,
    input logic          in_ready,
    input logic [W-1:0]  in_data,
    input logic          in_head,
    input logic          in_last,
    input logic          out_valid,
    input logic          out_ready,
    input logic [W-1:0]  out_data,
    input logic          out_first,
    input logic          sum_valid,
    input logic          sum_ready,
    input logic [W-1:0]  sum_data
);

    localparam logic [W-1:0] IDENT = (OP == OP_MAX) ? {1'b1, {(W-1){1'b0}}} : '0;

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !sum_valid && in_ready));

    a_r3_head_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_head && !excl_mode)
        |=> (out_data == $past(in_data) && out_first));

    a_r4_head_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_head && excl_mode)
        |=> (out_data == IDENT && out_first));

    a_r7_last_queues_total: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> sum_valid);

    a_r8_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r8_hold_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready)
        |=> (out_valid && $stable(out_data) && $stable(out_first)));

    a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r9_hold_total: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && !sum_ready) |=> (sum_valid && $stable(sum_data)));

endmodule

bind seg_scan_unit seg_scan_unit_chk #(.W(W), .OP(OP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .excl_mode (excl_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_head   (in_head),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_first (out_first),
    .sum_valid (sum_valid),
    .sum_ready (sum_ready),
    .sum_data  (sum_data)
);

// File: tb/tb_seg_scan_unit.sv
`timescale 1ns/1ps
module tb_seg_scan_unit;
    import seg_scan_pkg::*;

    localparam int W = 16;
    localparam logic [W-1:0] MAX_ID = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         excl_mode = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_head = 1'b0;
    logic         in_last = 1'b0;
    logic         out_ready = 1'b1;
    logic         sum_ready = 1'b1;

    logic         in_ready, out_valid, out_first, sum_valid;
    logic [W-1:0] out_data, sum_data;
    logic         m_in_ready, m_out_valid, m_out_first, m_sum_valid;
    logic [W-1:0] m_out_data, m_sum_data;

    seg_scan_unit #(.W(W), .OP(OP_ADD), .TOT_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .excl_mode(excl_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_head(in_head), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .sum_valid(sum_valid), .sum_ready(sum_ready),
        .sum_data(sum_data));

    seg_scan_unit #(.W(W), .OP(OP_MAX), .TOT_DEPTH(4)) dut_max (
        .clk(clk), .rst_n(rst_n), .excl_mode(excl_mode),
        .in_valid(in_valid), .in_ready(m_in_ready), .in_data(in_data),
        .in_head(in_head), .in_last(in_last),
        .out_valid(m_out_valid), .out_ready(out_ready), .out_data(m_out_data),
        .out_first(m_out_first), .sum_valid(m_sum_valid), .sum_ready(sum_ready),
        .sum_data(m_sum_data));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference model state
    logic [W-1:0] ma_acc = '0;
    logic [W-1:0] mm_acc = '0;
    bit           m_open = 0;
    logic [W-1:0] q_pa[$];
    logic [W-1:0] q_pm[$];
    string        q_pt[$];
    logic [W-1:0] q_sa[$];
    logic [W-1:0] q_sm[$];
    string        q_st[$];

    bit rdy_rand = 0;
    bit force_or = 1;
    bit force_sr = 1;
    bit lat_pend = 0;

    function automatic logic [W-1:0] smax(input logic [W-1:0] a, input logic [W-1:0] b);
        return ($signed(a) > $signed(b)) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one accepted element; fills the expectation queues
    task automatic model_take(input logic [W-1:0] d, input bit h, input bit l, input bit x);
        bit eff;
        logic [W-1:0] inc_a, inc_m, ex_a, ex_m;
        string t;
        eff = h || !m_open;
        if (h && m_open) begin
            q_sa.push_back(ma_acc); q_sm.push_back(mm_acc); q_st.push_back("R6");
        end
        inc_a = eff ? d : ma_acc + d;
        inc_m = eff ? d : smax(mm_acc, d);
        ex_a  = eff ? '0 : ma_acc;
        ex_m  = eff ? MAX_ID : mm_acc;
        if (x) t = "R4";
        else if (eff && !h) t = "R5";
        else if (eff) t = "R3";
        else t = "R2";
        q_pa.push_back(x ? ex_a : inc_a);
        q_pm.push_back(x ? ex_m : inc_m);
        q_pt.push_back(t);
        if (l) begin
            q_sa.push_back(inc_a); q_sm.push_back(inc_m); q_st.push_back("R7");
        end
        ma_acc = inc_a;
        mm_acc = inc_m;
        m_open = !l;
    endtask

    task automatic lat_check();
        if (lat_pend) begin
            check(out_valid == 1'b1, "R8 next-cycle valid", W'(out_valid), 16'd1);
            lat_pend = 0;
        end
    endtask

    // Offer one element until it is accepted
    task automatic send(input logic [W-1:0] d, input bit h, input bit l, input bit x);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_head = h; in_last = l; excl_mode = x;
            #1;
            lat_check();
            if (in_ready) begin
                model_take(d, h, l, x);
                lat_pend = 1;
                done = 1;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            lat_check();
        end
    endtask

    // Ready drivers for both output channels
    initial begin
        forever begin
            @(negedge clk);
            if (rdy_rand) begin
                out_ready = ($urandom % 4) != 0;
                sum_ready = ($urandom % 3) != 0;
            end else begin
                out_ready = force_or;
                sum_ready = force_sr;
            end
        end
    end

    // Output monitor: compares transfers and stalls against the model
    initial begin
        bit p_ostall = 0, p_sstall = 0, p_first = 0;
        logic [W-1:0] p_od = '0, p_sd = '0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && !finished) begin
                if (p_ostall) begin
                    check(out_valid && out_data == p_od && out_first == p_first,
                          "R8 prefix held", out_data, p_od);
                end
                if (p_sstall) begin
                    check(sum_valid && sum_data == p_sd, "R9 total held", sum_data, p_sd);
                end
                if (out_valid && out_ready) begin
                    if (q_pa.size() == 0) begin
                        check(0, "R9 unexpected prefix", out_data, '0);
                    end else begin
                        logic [W-1:0] ea, em;
                        string t;
                        ea = q_pa.pop_front(); em = q_pm.pop_front(); t = q_pt.pop_front();
                        check(out_data == ea, t, out_data, ea);
                        check(m_out_valid && m_out_data == em, {"R10 ", t}, m_out_data, em);
                    end
                end
                if (sum_valid && sum_ready) begin
                    if (q_sa.size() == 0) begin
                        check(0, "R9 unexpected total", sum_data, '0);
                    end else begin
                        logic [W-1:0] ea, em;
                        string t;
                        ea = q_sa.pop_front(); em = q_sm.pop_front(); t = q_st.pop_front();
                        check(sum_data == ea, t, sum_data, ea);
                        check(m_sum_valid && m_sum_data == em, {"R10 ", t}, m_sum_data, em);
                    end
                end
                p_ostall = out_valid && !out_ready;
                p_od     = out_data;
                p_first  = out_first;
                p_sstall = sum_valid && !sum_ready;
                p_sd     = sum_data;
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Main stimulus
    initial begin
        int acc_n;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        check(!out_valid && !sum_valid, "R1 reset outputs", W'({out_valid, sum_valid}), '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1'b1, "R1 ready after reset", W'(in_ready), 16'd1);
        check(!out_valid && !sum_valid, "R1 idle after reset", W'({out_valid, sum_valid}), '0);

        // Directed: implied head, wrap, head closure, last closure, collision
        send(16'd5, 0, 0, 0);          // R5 first element, flag clear
        send(16'd7, 0, 0, 0);          // R2
        send(16'h8009, 0, 0, 0);       // R2, negative for max
        send(16'hFFFF, 1, 0, 0);       // R6 closes previous, R3
        send(16'd2, 0, 0, 0);          // R2 wraps to 1
        send(16'd3, 0, 1, 0);          // R7 explicit end
        send(16'd10, 0, 0, 0);         // R5 after explicit end
        send(16'd6, 1, 1, 0);          // R6 then R7 ordering
        send(16'hFFF0, 1, 0, 1);       // R4 identity
        send(16'd4, 0, 0, 1);          // R4
        send(16'h7FFF, 0, 0, 1);       // R4
        send(16'd1, 0, 1, 0);          // R7 wrap total
        idle(3);

        // Directed: total queue fills while sum consumer is held
        force_sr = 0;
        idle(2);
        acc_n = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = W'(k + 1); in_head = 1'b1; in_last = 1'b1;
            excl_mode = 1'b0;
            #1;
            lat_check();
            if (in_ready) begin
                model_take(W'(k + 1), 1, 1, 0);
                lat_pend = 1;
                acc_n++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        lat_check();
        check(in_ready == 1'b0, "R9 stall when queue full", W'(in_ready), '0);
        check(acc_n == 3, "R9 accepted before stall", W'(acc_n), 16'd3);
        force_sr = 1;
        idle(6);

        // Random phase with throttled consumers
        rdy_rand = 1;
        for (int i = 0; i < 800; i++) begin
            logic [W-1:0] d;
            bit h, l, x;
            d = (($urandom % 3) == 0) ? W'($urandom) : W'($urandom % 32) - W'(12);
            h = ($urandom % 4) == 0;
            l = ($urandom % 7) == 0;
            x = ($urandom % 3) == 0;
            send(d, h, l, x);
            if (($urandom % 10) == 0) idle(1 + ($urandom % 3));
        end
        idle(1);
        rdy_rand = 0;
        force_or = 1;
        force_sr = 1;
        idle(30);
        check(q_pa.size() == 0, "R9 all prefixes delivered", W'(q_pa.size()), '0);
        check(q_sa.size() == 0, "R9 all totals delivered", W'(q_sa.size()), '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule